// File: doc/BRIEF.md
# Reference clock input selector

This block picks one reference clock out of fourteen candidate inputs for a timing path. It takes each input's quality verdict from an external monitor and a software mask that allows or blocks locking to that input. It also takes a 4-bit rank code per input and two forced-select fields, one for each of two timing paths. It returns the index of the chosen input, a flag saying whether that index is usable, and the per-input qualification vector.

There are two modes. In forced mode the index comes straight from the forced-select field of the path named by the path-select bit, and monitor results, masks and ranks play no part. In automatic mode the block looks only at inputs that are both monitor-valid and allowed, and that have a nonzero rank code. Among those it takes the best-ranked one. Code 1 is the best rank and 15 the worst, and a tie goes to the lowest-numbered input. When nothing can be selected, the valid flag drops and the index keeps its previous value, so the downstream loop sees a stable reference number.

Top module: `refclk_selector`

## Requirements
- R1: While reset is asserted, `sel_idx` is 0, `sel_valid` is 0 and `qual_vec` is all zeros.
- R2: Bit n-1 of `qual_vec` is 1 exactly when `mon_ok[n-1]` and `lock_allow[n-1]` are both 1. It is reported in both modes and follows the inputs with one clock of latency.
- R3: In forced mode (`mode_auto`=0), a forced code from 1 to 14 gives `sel_idx` equal to the code and `sel_valid`=1, whatever the monitor, mask and rank inputs are.
- R4: In forced mode, a forced code of 0 or 15 gives `sel_valid`=0 and `sel_idx` keeps its previous value.
- R5: In automatic mode (`mode_auto`=1), input n is a candidate only if it is qualified (R2) and its rank code, `prio_flat[4(n-1)+3 : 4(n-1)]`, is nonzero. An input with rank code 0 is never selected.
- R6: In automatic mode, `sel_idx` is the candidate with the numerically smallest rank code, and `sel_valid`=1.
- R7: When several candidates share the smallest rank code, the one with the lowest index n is selected.
- R8: In automatic mode with no candidate, `sel_valid`=0 and `sel_idx` keeps its previous value.
- R9: `path_b_sel`=0 makes forced mode use `force_code_a`, and `path_b_sel`=1 makes it use `force_code_b`. The field that is not chosen has no effect.
- R10: `sel_idx` and `sel_valid` change only at a rising clock edge. They reflect the inputs present just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_auto | input | 1 | 1 = automatic selection, 0 = forced selection |
| path_b_sel | input | 1 | Chooses which forced-select field applies (0 = A, 1 = B) |
| force_code_a | input | 4 | Forced input number for path A (1..14 valid) |
| force_code_b | input | 4 | Forced input number for path B (1..14 valid) |
| mon_ok | input | 14 | Per-input monitor verdict, bit n-1 for input n |
| lock_allow | input | 14 | Per-input locking-allowance mask, bit n-1 for input n |
| prio_flat | input | 56 | Rank codes, 4 bits per input, input n at bits 4(n-1)+3..4(n-1) |
| sel_idx | output | 4 | Selected input number (1..14), 0 after reset |
| sel_valid | output | 1 | The selected index is usable |
| qual_vec | output | 14 | Registered per-input qualification |

## Verification
The hardest situation to reach from the ports has three parts at once: a wide tie at the best rank, a better-ranked input that is left out only because its rank code is zero or it is masked, and a drop of the valid flag that must leave the previous index in place. The stimulus draws rank codes from the narrow range 0 to 3, so ties and zero-rank exclusions appear in almost every vector. It biases monitor and mask bits so that empty candidate sets also occur often. It switches mode, path and forced codes at random between cycles, so the held index is tested right after both forced and automatic selections.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
   localparam int unsigned REFSEL_MAX_INPUTS = 15;
   typedef enum logic {
      SEL_FORCED = 1'b0,
      SEL_AUTO   = 1'b1
   } sel_mode_e;
endpackage

// File: rtl/refsel_qualify.sv
module refsel_qualify #(
   parameter int unsigned NUM_IN = 14,
   parameter int unsigned PRIO_W = 4
) (
   input  logic [NUM_IN-1:0]        mon_ok,
   input  logic [NUM_IN-1:0]        lock_allow,
   input  logic [NUM_IN*PRIO_W-1:0] prio_flat,
   output logic [NUM_IN-1:0]        qual,
   output logic [NUM_IN-1:0]        cand
);
   generate
      for (genvar g = 0; g < NUM_IN; g++) begin : g_in
         logic [PRIO_W-1:0] rank;
         assign rank    = prio_flat[g*PRIO_W +: PRIO_W];
         assign qual[g] = mon_ok[g] & lock_allow[g];
         assign cand[g] = qual[g] & (rank != '0);
      end
   endgenerate
endmodule

// File: rtl/refsel_rank.sv
module refsel_rank #(
   parameter int unsigned NUM_IN = 14,
   parameter int unsigned PRIO_W = 4,
   parameter int unsigned IDX_W  = 4
) (
   input  logic [NUM_IN-1:0]        cand,
   input  logic [NUM_IN*PRIO_W-1:0] prio_flat,
   output logic                     win_valid,
   output logic [IDX_W-1:0]         win_idx
);
   logic [NUM_IN:0]   chain_v;
   logic [PRIO_W-1:0] chain_p [NUM_IN+1];
   logic [IDX_W-1:0]  chain_i [NUM_IN+1];

   assign chain_v[0] = 1'b0;
   assign chain_p[0] = '1;
   assign chain_i[0] = '0;

   generate
      for (genvar g = 0; g < NUM_IN; g++) begin : g_stage
         logic [PRIO_W-1:0] rank;
         logic              take;
         assign rank = prio_flat[g*PRIO_W +: PRIO_W];
         // strict compare: an equal rank never displaces a lower index
         assign take = cand[g] & (~chain_v[g] | (rank < chain_p[g]));
         assign chain_v[g+1] = chain_v[g] | cand[g];
         assign chain_p[g+1] = take ? rank : chain_p[g];
         assign chain_i[g+1] = take ? IDX_W'(g + 1) : chain_i[g];
      end
   endgenerate

   assign win_valid = chain_v[NUM_IN];
   assign win_idx   = chain_i[NUM_IN];
endmodule

// File: rtl/refsel_forced_dec.sv
module refsel_forced_dec #(
   parameter int unsigned NUM_IN = 14,
   parameter int unsigned IDX_W  = 4
) (
   input  logic [IDX_W-1:0] code_a,
   input  logic [IDX_W-1:0] code_b,
   input  logic             path_b,
   output logic             f_valid,
   output logic [IDX_W-1:0] f_idx
);
   logic [IDX_W-1:0] code;
   assign code    = path_b ? code_b : code_a;
   assign f_idx   = code;
   assign f_valid = (code != '0) && (code <= IDX_W'(NUM_IN));
endmodule

// File: rtl/refclk_selector.sv
module refclk_selector
   import refsel_pkg::*;
#(
   parameter int unsigned NUM_IN = 14,
   parameter int unsigned PRIO_W = 4,
   localparam int unsigned IDX_W = $clog2(NUM_IN + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     mode_auto,
   input  logic                     path_b_sel,
   input  logic [IDX_W-1:0]         force_code_a,
   input  logic [IDX_W-1:0]         force_code_b,
   input  logic [NUM_IN-1:0]        mon_ok,
   input  logic [NUM_IN-1:0]        lock_allow,
   input  logic [NUM_IN*PRIO_W-1:0] prio_flat,
   output logic [IDX_W-1:0]         sel_idx,
   output logic                     sel_valid,
   output logic [NUM_IN-1:0]        qual_vec
);
   generate
      if (NUM_IN < 1 || NUM_IN > REFSEL_MAX_INPUTS) begin : g_bad_count
         $error("refclk_selector: NUM_IN out of supported range");
      end
      if (PRIO_W < 1) begin : g_bad_prio
         $error("refclk_selector: PRIO_W must be at least 1");
      end
   endgenerate

   sel_mode_e         mode;
   logic [NUM_IN-1:0] qual_c;
   logic [NUM_IN-1:0] cand_c;
   logic              a_valid;
   logic [IDX_W-1:0]  a_idx;
   logic              f_valid;
   logic [IDX_W-1:0]  f_idx;
   logic              nxt_valid;
   logic [IDX_W-1:0]  nxt_idx;

   assign mode = sel_mode_e'(mode_auto);

   refsel_qualify #(.NUM_IN(NUM_IN), .PRIO_W(PRIO_W)) qual_i (
      .mon_ok(mon_ok), .lock_allow(lock_allow), .prio_flat(prio_flat),
      .qual(qual_c), .cand(cand_c)
   );

   refsel_rank #(.NUM_IN(NUM_IN), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) rank_i (
      .cand(cand_c), .prio_flat(prio_flat),
      .win_valid(a_valid), .win_idx(a_idx)
   );

   refsel_forced_dec #(.NUM_IN(NUM_IN), .IDX_W(IDX_W)) force_i (
      .code_a(force_code_a), .code_b(force_code_b), .path_b(path_b_sel),
      .f_valid(f_valid), .f_idx(f_idx)
   );

   always_comb begin
      if (mode == SEL_AUTO) begin
         nxt_valid = a_valid;
         nxt_idx   = a_idx;
      end else begin
         nxt_valid = f_valid;
         nxt_idx   = f_idx;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_idx   <= '0;
         sel_valid <= 1'b0;
         qual_vec  <= '0;
      end else begin
         qual_vec  <= qual_c;
         sel_valid <= nxt_valid;
         if (nxt_valid) sel_idx <= nxt_idx;
      end
   end

   assert_qual_track_R2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (qual_vec == $past(mon_ok & lock_allow)));

   assert_forced_pick_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_auto && !path_b_sel && force_code_a != '0 && force_code_a <= IDX_W'(NUM_IN))
      |=> (sel_valid && sel_idx == $past(force_code_a)));

   assert_hold_on_invalid_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_valid |-> $stable(sel_idx));

   assert_auto_candidate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode_auto) && sel_valid)
      |-> (sel_idx != '0 && ((($past(cand_c)) >> (sel_idx - 1'b1)) & NUM_IN'(1)) != '0));

   assert_idx_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sel_valid |-> (sel_idx != '0 && sel_idx <= IDX_W'(NUM_IN)));
endmodule

// File: tb/refclk_selector_tb_top.sv
module refclk_selector_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int N = 14;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_auto = 1'b0;
   logic        path_b_sel = 1'b0;
   logic [3:0]  force_code_a = '0;
   logic [3:0]  force_code_b = '0;
   logic [N-1:0] mon_ok = '0;
   logic [N-1:0] lock_allow = '0;
   logic [N*4-1:0] prio_flat = '0;
   logic [3:0]  sel_idx;
   logic        sel_valid;
   logic [N-1:0] qual_vec;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;
   logic [3:0] exp_idx = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   refclk_selector dut_i (
      .clk(clk), .rst_n(rst_n), .mode_auto(mode_auto), .path_b_sel(path_b_sel),
      .force_code_a(force_code_a), .force_code_b(force_code_b),
      .mon_ok(mon_ok), .lock_allow(lock_allow), .prio_flat(prio_flat),
      .sel_idx(sel_idx), .sel_valid(sel_valid), .qual_vec(qual_vec)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // expected selection from the requirements; updates the held index
   task automatic model(output logic v, output string tag);
      logic [3:0] code, best, p;
      int ties;
      v = 1'b0; tag = "R8";
      if (!mode_auto) begin
         code = path_b_sel ? force_code_b : force_code_a;
         if (code >= 1 && code <= N) begin
            v = 1'b1; exp_idx = code;
            tag = path_b_sel ? "R9" : "R3";
         end else tag = "R4";
      end else begin
         best = 4'd15; ties = 0;
         for (int n = 0; n < N; n++) begin
            p = prio_flat[4*n +: 4];
            if (mon_ok[n] && lock_allow[n] && p != 0) begin
               if (!v || p < best) begin best = p; v = 1'b1; exp_idx = 4'(n + 1); end
            end
         end
         if (v) begin
            for (int n = 0; n < N; n++)
               if (mon_ok[n] && lock_allow[n] && prio_flat[4*n +: 4] == best) ties++;
            tag = (ties > 1) ? "R7" : "R6";
         end
      end
   endtask

   task automatic step_check();
      logic v; string tag;
      logic [N-1:0] q;
      q = mon_ok & lock_allow;
      model(v, tag);
      @(posedge clk); #1;
      chk({tag, " valid"}, 32'(sel_valid), 32'(v));
      chk({tag, " idx"}, 32'(sel_idx), 32'(exp_idx));
      chk("R2 qual", 32'(qual_vec), 32'(q));
   endtask

   task automatic set_all_prio(input logic [3:0] p);
      for (int n = 0; n < N; n++) prio_flat[4*n +: 4] = p;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      mon_ok = '1; lock_allow = '1; set_all_prio(4'd1); mode_auto = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      chk("R1 idx", 32'(sel_idx), 0);
      chk("R1 valid", 32'(sel_valid), 0);
      chk("R1 qual", 32'(qual_vec), 0);
      @(negedge clk); rst_n = 1'b1;
      #1;

      // R7: all equal rank -> input 1
      step_check();
      chk("R7 directed", 32'(sel_idx), 1);
      // R5: better rank on a zero-code input is excluded; input 5 rank 0, input 9 rank 2
      set_all_prio(4'd3); prio_flat[4*4 +: 4] = 4'd0; prio_flat[4*8 +: 4] = 4'd2;
      step_check();
      chk("R5 directed", 32'(sel_idx), 9);
      // R5: masked input with best rank is excluded
      prio_flat[4*2 +: 4] = 4'd1; lock_allow[2] = 1'b0;
      step_check();
      chk("R5 mask", 32'(sel_idx), 9);
      // R6: only input 14 a candidate
      mon_ok = 14'h2000; step_check();
      chk("R6 last input", 32'(sel_idx), 14);
      // R8: none -> hold 14
      mon_ok = '0; step_check();
      chk("R8 hold", 32'(sel_idx), 14);
      // R3: forced ignores monitoring
      mode_auto = 1'b0; force_code_a = 4'd7; force_code_b = 4'd2; step_check();
      chk("R3 ignores monitor", 32'(sel_idx), 7);
      // R9: path B field used, A ignored
      path_b_sel = 1'b1; step_check();
      chk("R9 path b", 32'(sel_idx), 2);
      // R4: code 15 -> invalid, hold
      force_code_b = 4'd15; step_check();
      chk("R4 code 15", 32'(sel_idx), 2);
      force_code_b = 4'd0; step_check();
      // R10: no change before the edge, change after it
      force_code_b = 4'd11;
      #1;
      chk("R10 before edge", 32'(sel_valid), 0);
      step_check();
      chk("R10 after edge", 32'(sel_idx), 11);

      // forced sweep, both paths, every code
      for (int pth = 0; pth < 2; pth++)
         for (int c = 0; c < 16; c++) begin
            path_b_sel = pth[0];
            force_code_a = pth[0] ? 4'(15 - c) : 4'(c);
            force_code_b = pth[0] ? 4'(c) : 4'(15 - c);
            mon_ok = 14'($urandom); lock_allow = 14'($urandom);
            step_check();
         end

      // mixed random sweep, narrow rank range for ties and exclusions
      for (int it = 0; it < 4000; it++) begin
         mode_auto = ($urandom % 4) != 0;
         path_b_sel = 1'($urandom);
         force_code_a = 4'($urandom); force_code_b = 4'($urandom);
         mon_ok = 14'($urandom) | 14'($urandom);
         lock_allow = ($urandom % 3 == 0) ? 14'($urandom) & 14'($urandom) : 14'($urandom) | 14'($urandom);
         for (int n = 0; n < N; n++) prio_flat[4*n +: 4] = 4'($urandom % 4);
         step_check();
      end

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule